// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit product, which never wraps. Every partial-product bit is the AND of one multiplicand bit with one multiplier bit. The bits whose weight involves exactly one operand's sign bit are inverted. Two constant ones then complete the sign correction. With these steps the whole array only adds, and no row needs a subtractor.

The rows are reduced by a chain of full-adder levels that does not propagate carries sideways. Each level keeps its sum vector and hands its carry vector one position up, diagonally into the next level. After the last level, a vector-merging adder turns the remaining sum and carry vectors into the product. This merge adder is either a ripple chain or a logarithmic prefix tree, chosen at build time. An optional output register, cleared by a synchronous active-high reset, adds one cycle of latency.

Top module: `smul_csa_top`

## Requirements
- R1: For every pair of operands, `product` read as a signed 2N-bit value equals the signed product of `mcand` and `mplier`, each read as N-bit two's complement.
- R2: With `REG_OUT`=1, `product` changes only at a rising clock edge and shows the operands present at the previous edge. With `REG_OUT`=0, `product` follows the operands within the same cycle.
- R3: With `REG_OUT`=1, a clock edge that finds `rst` high sets `product` to zero, whatever the operands are.
- R4: The most negative operand times itself gives +2^(2N-2). Bit 2N-2 is set and the sign bit 2N-1 is clear.
- R5: -1 times -1 gives +1.
- R6: If either operand is zero, the product is zero.
- R7: The top bit 2N-1 of `product` is 1 exactly when both operands are nonzero and their sign bits differ.
- R8: The ripple merge adder (`MERGE`=MERGE_RIPPLE) and the prefix merge adder (`MERGE`=MERGE_PREFIX) give identical products for identical operands.
- R9: The most negative operand times the most positive one gives -2^(2N-2)+2^(N-1), which is the most negative product reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| product | output | 2N | Signed product |

## Verification
In one cycle, the inverted sign-cross terms and the two injected constant ones can both carry into the top columns, and the merge adder must then resolve a carry that runs the whole width. The most negative operand squared and -1 squared provoke exactly this. The default 8-bit configuration sweeps every operand pair, and so do two 4-bit builds, one per merge-adder variant. Each product is judged against integer multiplication done in the bench, the sign bit is judged on its own, and the two 4-bit builds are compared with each other.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Which structure resolves the final sum and carry vectors
    typedef enum logic [0:0] {
        MERGE_RIPPLE = 1'b0,
        MERGE_PREFIX = 1'b1
    } merge_kind_e;

    // Generate / propagate pair used by the merge adder
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Prefix combine: higher-order group absorbs lower-order group
    function automatic gp_t gp_dot(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // A partial-product bit is inverted when exactly one of its indices is the sign bit
    function automatic logic pp_flip(int unsigned i, int unsigned j, int unsigned n);
        return (i == n - 1) != (j == n - 1);
    endfunction

    // One full-adder column: sum and majority
    function automatic logic fa_sum(logic x, logic y, logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic fa_maj(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/smul_ppgen.sv
module smul_ppgen
    import smul_pkg::*;
#(
    parameter int N = 8,
    localparam int W = 2 * N
) (
    input  logic [N-1:0]        a_op,
    input  logic [N-1:0]        b_op,
    output logic [N-1:0][W-1:0] rows
);

    // Correction ones at weight 2^N and 2^(2N-1); both lie outside row 0's bits
    localparam logic [W-1:0] BIAS = (W'(1) << N) | (W'(1) << (W - 1));

    for (genvar j = 0; j < N; j++) begin : g_row
        logic [N-1:0] term;
        for (genvar i = 0; i < N; i++) begin : g_col
            if (pp_flip(i, j, N)) begin : g_inv
                assign term[i] = ~(a_op[i] & b_op[j]);
            end else begin : g_pos
                assign term[i] = a_op[i] & b_op[j];
            end
        end
        if (j == 0) begin : g_bias
            assign rows[j] = W'(term) | BIAS;
        end else begin : g_shift
            assign rows[j] = W'(term) << j;
        end
    end

endmodule

// File: rtl/smul_csa_level.sv
module smul_csa_level
    import smul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sum_in,
    input  logic [W-1:0] carry_in,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out
);

    // Carry of column k is passed diagonally to column k+1 of the next level
    logic [W-2:0] maj;

    for (genvar k = 0; k < W; k++) begin : g_sum
        assign sum_out[k] = fa_sum(sum_in[k], carry_in[k], addend[k]);
    end

    for (genvar k = 0; k < W - 1; k++) begin : g_maj
        assign maj[k] = fa_maj(sum_in[k], carry_in[k], addend[k]);
    end

    assign carry_out = {maj, 1'b0};

endmodule

// File: rtl/smul_merge.sv
module smul_merge
    import smul_pkg::*;
#(
    parameter int          W    = 16,
    parameter merge_kind_e KIND = MERGE_PREFIX
) (
    input  logic [W-1:0] x_vec,
    input  logic [W-1:0] y_vec,
    output logic [W-1:0] total
);

    logic [W-1:0] cy;

    if (KIND == MERGE_RIPPLE) begin : g_ripple
        always_comb begin
            cy[0] = 1'b0;
            for (int k = 1; k < W; k++) begin
                cy[k] = (x_vec[k-1] & y_vec[k-1]) |
                        ((x_vec[k-1] ^ y_vec[k-1]) & cy[k-1]);
            end
        end
    end else begin : g_prefix
        gp_t [W-1:0] cur;
        gp_t [W-1:0] nxt;
        always_comb begin
            for (int k = 0; k < W; k++) begin
                cur[k].g = x_vec[k] & y_vec[k];
                cur[k].p = x_vec[k] ^ y_vec[k];
            end
            nxt = cur;
            for (int s = 1; s < W; s = s * 2) begin
                nxt = cur;
                for (int k = s; k < W; k++) begin
                    nxt[k] = gp_dot(cur[k], cur[k-s]);
                end
                cur = nxt;
            end
            cy[0] = 1'b0;
            for (int k = 1; k < W; k++) begin
                cy[k] = cur[k-1].g;
            end
        end
    end

    assign total = x_vec ^ y_vec ^ cy;

endmodule

// File: rtl/smul_csa_top.sv
module smul_csa_top
    import smul_pkg::*;
#(
    parameter int          N       = 8,
    parameter merge_kind_e MERGE   = MERGE_PREFIX,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     mcand,
    input  logic [N-1:0]     mplier,
    output logic [2*N-1:0]   product
);

    localparam int W = 2 * N;

    typedef struct packed {
        logic [W-1:0] sum;
        logic [W-1:0] carry;
    } csv_t;

    logic [N-1:0][W-1:0] pp_rows;
    csv_t [N-1:0]        stage;
    logic [W-1:0]        merged;

    smul_ppgen #(.N(N)) u_ppgen (
        .a_op (mcand),
        .b_op (mplier),
        .rows (pp_rows)
    );

    assign stage[0].sum   = pp_rows[0];
    assign stage[0].carry = '0;

    for (genvar j = 1; j < N; j++) begin : g_level
        smul_csa_level #(.W(W)) u_level (
            .sum_in    (stage[j-1].sum),
            .carry_in  (stage[j-1].carry),
            .addend    (pp_rows[j]),
            .sum_out   (stage[j].sum),
            .carry_out (stage[j].carry)
        );
    end

    smul_merge #(.W(W), .KIND(MERGE)) u_merge (
        .x_vec (stage[N-1].sum),
        .y_vec (stage[N-1].carry),
        .total (merged)
    );

    if (REG_OUT) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                product <= '0;
            end else begin
                product <= merged;
            end
        end
    end else begin : g_ocomb
        assign product = merged;
    end

endmodule

// File: rtl/smul_csa_chk.sv
module smul_csa_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic [2*N-1:0] product
);

    localparam int           W        = 2 * N;
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
    localparam logic [W-1:0] MIN_SQ   = W'(1) << (W - 2);

    if (REG_OUT) begin : g_seq
        // R1 R2
        prod_value_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> $signed(product) ==
                $signed($past(mcand)) * $signed($past(mplier)));

        // R3
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> product == '0);

        // R6
        zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ($past(mcand) == '0 || $past(mplier) == '0))
                |-> product == '0);

        // R7
        sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mcand) != '0 && $past(mplier) != '0)
                |-> product[W-1] == ($past(mcand[N-1]) ^ $past(mplier[N-1])));

        // R4
        min_square_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mcand) == MOST_NEG && $past(mplier) == MOST_NEG)
                |-> product == MIN_SQ);
    end else begin : g_comb
        // R1 R2
        comb_value_chk: assert property (@(posedge clk) disable iff (rst)
            $signed(product) == $signed(mcand) * $signed(mplier));

        // R6
        comb_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand == '0 || mplier == '0) |-> product == '0);

        // R7
        comb_sign_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand != '0 && mplier != '0)
                |-> product[W-1] == (mcand[N-1] ^ mplier[N-1]));

        // R4
        comb_min_square_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand == MOST_NEG && mplier == MOST_NEG) |-> product == MIN_SQ);
    end

endmodule

bind smul_csa_top smul_csa_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
);

// File: tb/smul_csa_top_bench.sv
module smul_csa_top_bench;
    import smul_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4r, p4c;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    smul_csa_top u_smul_csa_top (
        .clk (clk), .rst (rst), .mcand (a8), .mplier (b8), .product (p8)
    );

    smul_csa_top #(.N(4), .MERGE(MERGE_RIPPLE), .REG_OUT(1'b1)) u_smul_csa_top_n4r (
        .clk (clk), .rst (rst), .mcand (a4), .mplier (b4), .product (p4r)
    );

    smul_csa_top #(.N(4), .MERGE(MERGE_PREFIX), .REG_OUT(1'b0)) u_smul_csa_top_n4c (
        .clk (clk), .rst (rst), .mcand (a4), .mplier (b4), .product (p4c)
    );

    function automatic int sx8(logic [7:0] v);
        return int'($signed(v));
    endfunction

    function automatic int sx4(logic [3:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Drive both widths at a falling edge, then judge after the next rising edge
    task automatic apply(logic [7:0] a, logic [7:0] b, logic [3:0] c, logic [3:0] d);
        a8 = a; b8 = b; a4 = c; b4 = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R3: reset with nonzero operands keeps the registered outputs at zero
        a8 = 8'h5A; b8 = 8'h33; a4 = 4'h7; b4 = 4'h3;
        repeat (3) @(negedge clk);
        chk("R3 reset n8", p8, 0);
        chk("R3 reset n4", p4r, 0);
        rst = 1'b0;
        // R2: before the next rising edge the registered output still holds zero
        #1;
        chk("R2 hold before edge", p8, 0);
        chk("R2 comb same cycle", $signed(p4c), sx4(4'h7) * sx4(4'h3));
        @(negedge clk);
        chk("R2 one-cycle latency", $signed(p8), sx8(8'h5A) * sx8(8'h33));

        // R1 R6 R7 R8: full sweep of every operand pair
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                a8 = 8'(ai); b8 = 8'(bi); a4 = 4'(ai); b4 = 4'(bi);
                #1;
                chk("R1 comb n4", $signed(p4c), sx4(a4) * sx4(b4));
                @(negedge clk);
                if (a8 == 0 || b8 == 0) begin
                    chk("R6 zero operand", p8, 0);
                end else begin
                    chk("R1 product n8", $signed(p8), sx8(a8) * sx8(b8));
                end
                chk("R7 sign n8", p8[15], (sx8(a8) * sx8(b8)) < 0 ? 1 : 0);
                chk("R1 product n4 ripple", $signed(p4r), sx4(a4) * sx4(b4));
                chk("R8 ripple vs prefix", p4r, p4c);
            end
        end

        // Named corners
        apply(8'h80, 8'h80, 4'h8, 4'h8);
        chk("R4 min squared n8", p8, 16384);
        chk("R4 min squared n4", p4r, 64);
        apply(8'hFF, 8'hFF, 4'hF, 4'hF);
        chk("R5 minus one squared n8", p8, 1);
        chk("R5 minus one squared n4", p4r, 1);
        apply(8'h80, 8'h7F, 4'h8, 4'h7);
        chk("R9 most negative product n8", $signed(p8), -16256);
        chk("R9 most negative product n4", $signed(p4r), -56);
        apply(8'h00, 8'h80, 4'h0, 4'h8);
        chk("R6 zero times min", p8, 0);
        chk("R7 zero product sign", p8[15], 0);

        // R3: reset in mid-run clears a large product
        a8 = 8'h80; b8 = 8'h80; a4 = 4'h8; b4 = 4'h8;
        rst = 1'b1;
        @(negedge clk);
        chk("R3 mid-run reset n8", p8, 0);
        chk("R3 mid-run reset n4", p4r, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 after reset release", p8, 16384);

        report();
    end

endmodule